// File: doc/BRIEF.md
# Host Word to Byte-Link Bridge

This block lets a processor on a 32-bit register bus exchange data with a peer over a byte-wide, handshaked, point-to-point link. Words the host writes are queued in a transmit FIFO. They are then sent across the link as four bytes, lowest byte first. Bytes arriving from the peer are collected four at a time into words, and those words are queued in a receive FIFO for the host to read. The host reaches the data register with either one 32-bit access or two 16-bit accesses, and the data register answers at two offsets.

The link side has one shared byte lane and four handshake wires per channel: a request and acknowledge pair for each direction. The bridge owns the lane (transmit direction) after reset. It gives the lane up to the peer only when it has nothing left to send. It takes the lane back once an incoming word is complete and outgoing data is waiting. A control bit selects which of two physical channels the single bridge serves. Changing that bit abandons any byte group that is half done.

Three read-only status words report sticky error flags, the current direction and channel, and the fill level of each FIFO. This lets software poll the block without side effects.

Top module: `hlb_bridge`

## Requirements
- R1: After reset the general status reads 0, both FIFO status words read 0x0001_0000, the control word reads 0, channel 0 drives the lane (`lnk_doe` = 2'b01), and no request or acknowledge output is high.
- R2: A 32-bit write (`host_size` = 0) at offset 0x80 or 0x84 queues the word. Each word leaves as four bytes, bits 7:0 first. Each byte is held on the lane with the request high until the peer's acknowledge rises. The request then drops, and the next byte starts only after the acknowledge falls.
- R3: A 16-bit write (`host_size` = 1) at 0x84 stores `host_wdata[15:0]` as the upper half without queueing anything, and sets general status bit 4. A following 16-bit write at 0x80 queues {upper, `host_wdata[15:0]`} and clears bit 4.
- R4: A queueing write while the transmit FIFO is full is discarded, leaves the FIFO contents unchanged, and sets sticky general status bit 0.
- R5: Incoming bytes are taken on a request from the peer and answered with a four-phase acknowledge. The first byte of a group lands in bits 7:0. A word enters the receive FIFO only when the fourth byte is taken.
- R6: A 32-bit read at 0x80 or 0x84 returns the oldest received word and removes it. A 16-bit read at 0x84 returns its bits 31:16 in `host_rdata[15:0]` without removing it. A 16-bit read at 0x80 returns bits 15:0 and removes it.
- R7: A data read while the receive FIFO is empty returns 0 and sets sticky general status bit 1.
- R8: Offset 0x94 (receive) and 0x98 (transmit) report the entry count in bits 15:0, empty in bit 16 and full in bit 17. Offset 0x9C reads 0. Writes to 0x90 through 0x9C change nothing.
- R9: The lane turns to receive (general status bit 3 = 1, output enable low) only when the transmit FIFO is empty, no word is part-sent and the peer requests. It turns back when no incoming group is partial, the transmit FIFO holds a word and the peer request is low.
- R10: Bit 0 written at offset 0x88 selects the channel. It reads back at 0x88 and in general status bit 2. Only the selected channel's outputs are ever active, and the other channel's inputs are ignored.
- R11: Writing a different channel value discards a partial incoming group, restarts a part-sent outgoing word from its first byte on the new channel, and returns the lane to transmit.
- R12: While the receive FIFO is full, the fourth byte of a group is not acknowledged until a word has been read out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | 8 | Register byte offset |
| host_size | input | 1 | 0 = 32-bit access, 1 = 16-bit access |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for `host_addr`, valid in the same cycle |
| lnk_dout | output | 16 | Outgoing byte, channel c in bits 8c+7:8c |
| lnk_doe | output | 2 | Lane output enable per channel |
| lnk_din | input | 16 | Incoming byte, channel c in bits 8c+7:8c |
| lnk_req_o | output | 2 | Outgoing byte request per channel |
| lnk_ack_i | input | 2 | Peer acknowledge of an outgoing byte |
| lnk_req_i | input | 2 | Peer request for an incoming byte |
| lnk_ack_o | output | 2 | Acknowledge of an incoming byte |

## Verification
The assertions rely on the host issuing one access per strobe cycle and never asserting read and write together. They also rely on the peer following the four-phase order: an acknowledge rises only after our request is seen, a request drops only after our acknowledge, and the peer requests only while the lane is released or idle. The bench's peer tasks wait on each handshake edge before moving the next wire. They drive the lane only through the request they own, and they keep the host strobes to single-cycle pulses separated by idle cycles.

// File: rtl/hlb_pkg.sv
package hlb_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int BYTES_PER_WORD = WORD_W / BYTE_W;
    localparam int NUM_CH = 2;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_DATA_LO = 8'h80;
    localparam logic [ADDR_W-1:0] OFS_DATA_HI = 8'h84;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h88;
    localparam logic [ADDR_W-1:0] OFS_GEN     = 8'h90;
    localparam logic [ADDR_W-1:0] OFS_RXSTAT  = 8'h94;
    localparam logic [ADDR_W-1:0] OFS_TXSTAT  = 8'h98;

    typedef enum logic {DIR_TX = 1'b0, DIR_RX = 1'b1} dir_e;
    typedef enum logic [1:0] {HS_IDLE = 2'd0, HS_WAIT_HI = 2'd1, HS_WAIT_LO = 2'd2} hs_e;

    typedef struct packed {
        logic [13:0] rsv;
        logic        full;
        logic        empty;
        logic [15:0] count;
    } fifo_stat_t;

    typedef struct packed {
        logic [26:0] rsv;
        logic        staged;
        logic        rx_dir;
        logic        chan;
        logic        underflow;
        logic        overflow;
    } gen_stat_t;

    function automatic fifo_stat_t make_fifo_stat(input logic [15:0] cnt,
                                                  input logic full,
                                                  input logic empty);
        fifo_stat_t s;
        s.rsv   = '0;
        s.full  = full;
        s.empty = empty;
        s.count = cnt;
        return s;
    endfunction
endpackage

// File: rtl/hlb_fifo.sv
module hlb_fifo #(
    parameter int W = 32,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] cnt_q;
    logic             do_push, do_pop;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];
    assign count   = cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/hlb_tx_ser.sv
module hlb_tx_ser
    import hlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              enable,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    output logic              word_pop,
    output logic [BYTE_W-1:0] byte_out,
    output logic              req_o,
    input  logic              ack_i,
    output logic              busy
);
    localparam int IDX_W = $clog2(BYTES_PER_WORD);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES_PER_WORD - 1);

    hs_e             st;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st  <= HS_IDLE;
            idx <= '0;
        end else begin
            case (st)
                HS_IDLE:    if (enable && word_valid) st <= HS_WAIT_HI;
                HS_WAIT_HI: if (ack_i) st <= HS_WAIT_LO;
                HS_WAIT_LO: if (!ack_i) begin
                    st  <= HS_IDLE;
                    idx <= idx + 1'b1;
                end
                default:    st <= HS_IDLE;
            endcase
        end
    end

    assign req_o    = (st == HS_WAIT_HI);
    assign word_pop = (st == HS_WAIT_LO) && !ack_i && (idx == LAST) && !flush;
    assign byte_out = word[BYTE_W*idx +: BYTE_W];
    assign busy     = (st != HS_IDLE) || (idx != '0);
endmodule

// File: rtl/hlb_rx_asm.sv
module hlb_rx_asm
    import hlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              enable,
    input  logic              req_i,
    input  logic [BYTE_W-1:0] din,
    output logic              ack_o,
    input  logic              space,
    output logic              word_push,
    output logic [WORD_W-1:0] word,
    output logic              busy
);
    localparam int IDX_W = $clog2(BYTES_PER_WORD);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BYTES_PER_WORD - 1);

    hs_e                      st;
    logic [IDX_W-1:0]         idx;
    logic [WORD_W-BYTE_W-1:0] asm_q;
    logic                     take;

    assign take = enable && (st == HS_IDLE) && req_i && ((idx != LAST) || space);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st    <= HS_IDLE;
            idx   <= '0;
            asm_q <= '0;
        end else begin
            case (st)
                HS_IDLE: if (take) begin
                    for (int i = 0; i < BYTES_PER_WORD - 1; i++) begin
                        if (idx == IDX_W'(i)) asm_q[BYTE_W*i +: BYTE_W] <= din;
                    end
                    idx <= idx + 1'b1;
                    st  <= HS_WAIT_LO;
                end
                HS_WAIT_LO: if (!req_i) st <= HS_IDLE;
                default:    st <= HS_IDLE;
            endcase
        end
    end

    assign ack_o     = (st == HS_WAIT_LO);
    assign word_push = take && (idx == LAST) && !flush;
    assign word      = {din, asm_q};
    assign busy      = (st != HS_IDLE) || (idx != '0);
endmodule

// File: rtl/hlb_bridge.sv
module hlb_bridge
    import hlb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [7:0]               host_addr,
    input  logic                     host_size,
    input  logic [31:0]              host_wdata,
    output logic [31:0]              host_rdata,
    output logic [15:0]              lnk_dout,
    output logic [1:0]               lnk_doe,
    input  logic [15:0]              lnk_din,
    output logic [1:0]               lnk_req_o,
    input  logic [1:0]               lnk_ack_i,
    input  logic [1:0]               lnk_req_i,
    output logic [1:0]               lnk_ack_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int HALF_W = WORD_W / 2;

    // Control and status state
    logic              sel_q;
    dir_e              dir_q;
    logic [HALF_W-1:0] stage_q;
    logic              staged_q, ovf_q, unf_q;

    // Host decode
    logic is_data, wr32, wr_hi16, wr_lo16, ctrl_wr, chan_change;
    logic tx_push, rx_pop, data_rd;
    logic [WORD_W-1:0] tx_din;

    // FIFO and link-engine wires
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    logic [CNT_W-1:0]  tx_count, rx_count;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_pop, rx_push, tx_req, rx_ack, tx_busy, rx_busy;
    logic [BYTE_W-1:0] tx_byte, sel_din;
    logic              sel_ack_i, sel_req_i;

    assign is_data     = (host_addr == OFS_DATA_LO) || (host_addr == OFS_DATA_HI);
    assign wr32        = host_wr && is_data && !host_size;
    assign wr_hi16     = host_wr && (host_addr == OFS_DATA_HI) && host_size;
    assign wr_lo16     = host_wr && (host_addr == OFS_DATA_LO) && host_size;
    assign ctrl_wr     = host_wr && (host_addr == OFS_CTRL);
    assign chan_change = ctrl_wr && (host_wdata[0] != sel_q);
    assign tx_push     = wr32 || wr_lo16;
    assign tx_din      = wr32 ? host_wdata : {stage_q, host_wdata[HALF_W-1:0]};
    assign data_rd     = host_rd && is_data;
    assign rx_pop      = data_rd && !(host_size && (host_addr == OFS_DATA_HI));

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= 1'b0;
            dir_q    <= DIR_TX;
            stage_q  <= '0;
            staged_q <= 1'b0;
            ovf_q    <= 1'b0;
            unf_q    <= 1'b0;
        end else begin
            if (ctrl_wr) sel_q <= host_wdata[0];
            if (wr_hi16) begin
                stage_q  <= host_wdata[HALF_W-1:0];
                staged_q <= 1'b1;
            end else if (wr_lo16) begin
                staged_q <= 1'b0;
            end
            if (tx_push && tx_full) ovf_q <= 1'b1;
            if (data_rd && rx_empty) unf_q <= 1'b1;
            if (chan_change)
                dir_q <= DIR_TX;
            else if (dir_q == DIR_TX && !tx_busy && tx_empty && sel_req_i)
                dir_q <= DIR_RX;
            else if (dir_q == DIR_RX && !rx_busy && !tx_empty && !sel_req_i)
                dir_q <= DIR_TX;
        end
    end

    hlb_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst), .push(tx_push), .din(tx_din), .pop(tx_pop),
        .dout(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    hlb_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .push(rx_push), .din(rx_word), .pop(rx_pop),
        .dout(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    hlb_tx_ser u_tx (
        .clk(clk), .rst(rst), .flush(chan_change), .enable(dir_q == DIR_TX),
        .word_valid(!tx_empty), .word(tx_head), .word_pop(tx_pop),
        .byte_out(tx_byte), .req_o(tx_req), .ack_i(sel_ack_i), .busy(tx_busy)
    );

    hlb_rx_asm u_rx (
        .clk(clk), .rst(rst), .flush(chan_change), .enable(dir_q == DIR_RX),
        .req_i(sel_req_i), .din(sel_din), .ack_o(rx_ack), .space(!rx_full),
        .word_push(rx_push), .word(rx_word), .busy(rx_busy)
    );

    // Channel routing
    assign sel_ack_i = lnk_ack_i[sel_q];
    assign sel_req_i = lnk_req_i[sel_q];
    assign sel_din   = lnk_din[BYTE_W*sel_q +: BYTE_W];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic is_sel;
        assign is_sel = (sel_q == 1'(c));
        assign lnk_dout[BYTE_W*c +: BYTE_W] = is_sel ? tx_byte : '0;
        assign lnk_doe[c]   = is_sel && (dir_q == DIR_TX);
        assign lnk_req_o[c] = is_sel && tx_req;
        assign lnk_ack_o[c] = is_sel && rx_ack;
    end

    // Read mux
    gen_stat_t gen_s;
    assign gen_s = '{rsv: '0, staged: staged_q, rx_dir: (dir_q == DIR_RX),
                     chan: sel_q, underflow: unf_q, overflow: ovf_q};

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            OFS_DATA_LO, OFS_DATA_HI: begin
                if (rx_empty)
                    host_rdata = '0;
                else if (!host_size)
                    host_rdata = rx_head;
                else if (host_addr == OFS_DATA_HI)
                    host_rdata = {{HALF_W{1'b0}}, rx_head[WORD_W-1:HALF_W]};
                else
                    host_rdata = {{HALF_W{1'b0}}, rx_head[HALF_W-1:0]};
            end
            OFS_CTRL:   host_rdata = {31'b0, sel_q};
            OFS_GEN:    host_rdata = gen_s;
            OFS_RXSTAT: host_rdata = make_fifo_stat(16'(rx_count), rx_full, rx_empty);
            OFS_TXSTAT: host_rdata = make_fifo_stat(16'(tx_count), tx_full, tx_empty);
            default:    host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/hlb_bridge_chk.sv
module hlb_bridge_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             host_wr,
    input logic [7:0]       host_addr,
    input logic             host_size,
    input logic [1:0]       lnk_doe,
    input logic [1:0]       lnk_req_o,
    input logic [1:0]       lnk_ack_o,
    input logic             tx_req,
    input logic             sel_ack,
    input logic             tx_push,
    input logic             tx_pop,
    input logic             tx_full,
    input logic [CNT_W-1:0] tx_count,
    input logic             rx_push,
    input logic             ovf_q,
    input logic             unf_q
);
    logic ctrl_wr, hi16_wr;
    assign ctrl_wr = host_wr && (host_addr == 8'h88);
    assign hi16_wr = host_wr && host_size && (host_addr == 8'h84);

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !sel_ack && !ctrl_wr) |=> tx_req);

    assert_stage_no_push_R3: assert property (@(posedge clk) disable iff (rst)
        (hi16_wr && !tx_pop) |=> $stable(tx_count));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (tx_push && tx_full && !tx_pop) |=> $stable(tx_count));

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);

    assert_push_then_ack_R5: assert property (@(posedge clk) disable iff (rst)
        rx_push |=> (lnk_ack_o != 2'b00));

    assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        unf_q |=> unf_q);

    assert_no_ack_while_driving_R9: assert property (@(posedge clk) disable iff (rst)
        !((lnk_doe != 2'b00) && (lnk_ack_o != 2'b00)));

    assert_single_channel_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lnk_req_o | lnk_ack_o | lnk_doe));
endmodule

bind hlb_bridge hlb_bridge_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
    .host_size(host_size), .lnk_doe(lnk_doe), .lnk_req_o(lnk_req_o),
    .lnk_ack_o(lnk_ack_o), .tx_req(tx_req), .sel_ack(sel_ack_i),
    .tx_push(tx_push), .tx_pop(tx_pop), .tx_full(tx_full),
    .tx_count(tx_count), .rx_push(rx_push), .ovf_q(ovf_q), .unf_q(unf_q)
);

// File: tb/test_hlb_bridge.sv
module test_hlb_bridge;
    localparam int DEPTH = 4;
    localparam logic [7:0] A_LO = 8'h80, A_HI = 8'h84, A_CTRL = 8'h88,
                           A_GEN = 8'h90, A_RXS = 8'h94, A_TXS = 8'h98, A_RSV = 8'h9C;
    localparam logic [31:0] EMPTY_ST = 32'h0001_0000;
    localparam logic [31:0] FULL_ST  = 32'h0002_0000 | DEPTH;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_wr = 1'b0, host_rd = 1'b0, host_size = 1'b0;
    logic [7:0]  host_addr = 8'h00;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [15:0] lnk_dout, lnk_din = '0;
    logic [1:0]  lnk_doe, lnk_req_o, lnk_ack_o;
    logic [1:0]  lnk_ack_i = '0, lnk_req_i = '0;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    hlb_bridge #(.DEPTH(DEPTH)) i_hlb_bridge (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .lnk_dout(lnk_dout), .lnk_doe(lnk_doe),
        .lnk_din(lnk_din), .lnk_req_o(lnk_req_o), .lnk_ack_i(lnk_ack_i),
        .lnk_req_i(lnk_req_i), .lnk_ack_o(lnk_ack_o)
    );

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic sz, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_size = sz; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, input logic sz, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a; host_size = sz;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a; host_size = 1'b0;
        #1 d = host_rdata;
    endtask

    task automatic peer_get(input int c, output logic [7:0] b);
        int n = 0;
        b = 8'h00;
        while (!lnk_req_o[c] && n < 300) begin @(negedge clk); n++; end
        if (n >= 300) begin
            check("R2 request timeout", 32'(lnk_req_o[c]), 32'd1);
            return;
        end
        b = lnk_dout[8*c +: 8];
        lnk_ack_i[c] = 1'b1;
        n = 0;
        while (lnk_req_o[c] && n < 300) begin @(negedge clk); n++; end
        lnk_ack_i[c] = 1'b0;
        @(negedge clk);
    endtask

    task automatic peer_put(input int c, input logic [7:0] b);
        int n = 0;
        @(negedge clk);
        lnk_din[8*c +: 8] = b;
        lnk_req_i[c] = 1'b1;
        while (!lnk_ack_o[c] && n < 300) begin @(negedge clk); n++; end
        if (n >= 300) check("R5 acknowledge timeout", 32'(lnk_ack_o[c]), 32'd1);
        lnk_req_i[c] = 1'b0;
        n = 0;
        while (lnk_ack_o[c] && n < 300) begin @(negedge clk); n++; end
    endtask

    task automatic get_word(input int c, input logic [31:0] w, input string rq);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            peer_get(c, b);
            check(rq, {24'h0, b}, {24'h0, w[8*i +: 8]});
        end
    endtask

    task automatic put_word(input int c, input logic [31:0] w);
        for (int i = 0; i < 4; i++) peer_put(c, w[8*i +: 8]);
    endtask

    function automatic logic [31:0] pat(input int k);
        return (32'h9E37_79B9 * 32'(k + 1)) ^ 32'(k << 8);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        peek(A_GEN, r);  check("R1 gen", r, 32'h0);
        peek(A_RXS, r);  check("R1 rxstat", r, EMPTY_ST);
        peek(A_TXS, r);  check("R1 txstat", r, EMPTY_ST);
        peek(A_CTRL, r); check("R1 ctrl", r, 32'h0);
        check("R1 doe", 32'(lnk_doe), 32'h1);
        check("R1 req/ack", 32'({lnk_req_o, lnk_ack_o}), 32'h0);

        // R2: 32-bit words at both aliases, bytes LSB first
        for (int g = 0; g < 4; g++) begin
            hwrite(A_LO, 1'b0, pat(2*g));
            hwrite(A_HI, 1'b0, pat(2*g + 1));
            get_word(0, pat(2*g), "R2 byte order");
            get_word(0, pat(2*g + 1), "R2 byte order alias");
        end

        // R3: half-word writes
        for (int k = 0; k < 3; k++) begin
            hwrite(A_HI, 1'b1, {16'hFFFF, pat(k)[31:16]});
            peek(A_TXS, r); check("R3 staged no push", r, EMPTY_ST);
            peek(A_GEN, r); check("R3 staged bit", r, 32'h10);
            hwrite(A_LO, 1'b1, {16'hAAAA, pat(k)[15:0]});
            peek(A_TXS, r); check("R3 pushed", r, 32'h1);
            peek(A_GEN, r); check("R3 staged cleared", r, 32'h0);
            get_word(0, pat(k), "R3 joined word");
        end

        // R4: overflow with a stalled peer
        for (int k = 0; k < DEPTH; k++) hwrite(A_LO, 1'b0, pat(10 + k));
        peek(A_TXS, r); check("R4 full", r, FULL_ST);
        hwrite(A_HI, 1'b0, 32'hDEAD_BEEF);
        peek(A_TXS, r); check("R4 dropped", r, FULL_ST);
        peek(A_GEN, r); check("R4 overflow bit", r, 32'h1);
        for (int k = 0; k < DEPTH; k++) get_word(0, pat(10 + k), "R4 contents kept");
        peek(A_TXS, r); check("R4 drained", r, EMPTY_ST);

        // R5, R9: receive assembly
        for (int i = 0; i < 3; i++) peer_put(0, pat(20)[8*i +: 8]);
        peek(A_RXS, r); check("R5 partial not pushed", r, EMPTY_ST);
        peek(A_GEN, r); check("R9 receive direction", r, 32'h9);
        check("R9 lane released", 32'(lnk_doe), 32'h0);
        peer_put(0, pat(20)[31:24]);
        peek(A_RXS, r); check("R5 pushed after fourth", r, 32'h1);
        put_word(0, pat(21));
        put_word(0, pat(22));
        peek(A_RXS, r); check("R5 count", r, 32'h3);

        // R6: reads
        hread(A_LO, 1'b0, r); check("R6 read32", r, pat(20));
        hread(A_HI, 1'b1, r); check("R6 upper half", r, {16'h0, pat(21)[31:16]});
        peek(A_RXS, r); check("R6 upper no pop", r, 32'h2);
        hread(A_LO, 1'b1, r); check("R6 lower half", r, {16'h0, pat(21)[15:0]});
        peek(A_RXS, r); check("R6 lower pops", r, 32'h1);
        hread(A_HI, 1'b0, r); check("R6 read32 alias", r, pat(22));

        // R7: underflow
        hread(A_LO, 1'b0, r); check("R7 empty read", r, 32'h0);
        peek(A_GEN, r); check("R7 underflow bit", r, 32'hB);

        // R12: receive stall when full
        for (int k = 0; k < DEPTH; k++) put_word(0, pat(30 + k));
        peek(A_RXS, r); check("R12 full", r, FULL_ST);
        for (int i = 0; i < 3; i++) peer_put(0, pat(40)[8*i +: 8]);
        @(negedge clk);
        lnk_din[7:0] = pat(40)[31:24];
        lnk_req_i[0] = 1'b1;
        repeat (20) @(negedge clk);
        check("R12 no ack while full", 32'(lnk_ack_o[0]), 32'h0);
        hread(A_LO, 1'b0, r); check("R12 head word", r, pat(30));
        begin
            int n = 0;
            while (!lnk_ack_o[0] && n < 300) begin @(negedge clk); n++; end
            lnk_req_i[0] = 1'b0;
            n = 0;
            while (lnk_ack_o[0] && n < 300) begin @(negedge clk); n++; end
        end
        peek(A_RXS, r); check("R12 accepted after space", r, FULL_ST);
        for (int k = 1; k < DEPTH; k++) begin
            hread(A_HI, 1'b0, r); check("R12 drain", r, pat(30 + k));
        end
        hread(A_LO, 1'b0, r); check("R12 stalled word", r, pat(40));

        // R8: status format, reserved and read-only
        hwrite(A_GEN, 1'b0, 32'hFFFF_FFFF);
        hwrite(A_RXS, 1'b0, 32'hFFFF_FFFF);
        hwrite(A_TXS, 1'b0, 32'hFFFF_FFFF);
        hwrite(A_RSV, 1'b0, 32'hFFFF_FFFF);
        peek(A_GEN, r); check("R8 gen unchanged", r, 32'hB);
        peek(A_RXS, r); check("R8 rx unchanged", r, EMPTY_ST);
        peek(A_TXS, r); check("R8 tx unchanged", r, EMPTY_ST);
        peek(A_RSV, r); check("R8 reserved zero", r, 32'h0);
        peek(A_CTRL, r); check("R8 ctrl unchanged", r, 32'h0);

        // R9: back to transmit once a word waits
        hwrite(A_LO, 1'b0, pat(50));
        repeat (3) @(negedge clk);
        peek(A_GEN, r); check("R9 transmit again", r, 32'h3);
        check("R9 lane driven", 32'(lnk_doe), 32'h1);
        get_word(0, pat(50), "R9 word after turnaround");

        // R10: channel 1
        hwrite(A_CTRL, 1'b0, 32'h1);
        peek(A_CTRL, r); check("R10 ctrl readback", r, 32'h1);
        peek(A_GEN, r); check("R10 gen chan bit", r, 32'h7);
        check("R10 doe", 32'(lnk_doe), 32'h2);
        lnk_req_i[0] = 1'b1;
        repeat (5) @(negedge clk);
        peek(A_GEN, r); check("R10 other channel ignored", r, 32'h7);
        lnk_req_i[0] = 1'b0;
        hwrite(A_LO, 1'b0, pat(60));
        for (int i = 0; i < 4; i++) begin
            peer_get(1, b);
            check("R10 byte on channel 1", {24'h0, b}, {24'h0, pat(60)[8*i +: 8]});
            check("R10 channel 0 quiet", 32'({lnk_req_o[0], lnk_doe[0]}), 32'h0);
        end

        // R11: partial receive group discarded on switch
        peer_put(1, 8'h11);
        peer_put(1, 8'h22);
        hwrite(A_CTRL, 1'b0, 32'h0);
        peek(A_GEN, r); check("R11 direction reset", r, 32'h3);
        check("R11 doe", 32'(lnk_doe), 32'h1);
        put_word(0, pat(70));
        peek(A_RXS, r); check("R11 one word", r, 32'h1);
        hread(A_LO, 1'b0, r); check("R11 fresh group", r, pat(70));

        // R11: part-sent word restarts from byte 0 on new channel
        hwrite(A_LO, 1'b0, pat(80));
        peer_get(0, b); check("R11 first byte", {24'h0, b}, {24'h0, pat(80)[7:0]});
        peer_get(0, b); check("R11 second byte", {24'h0, b}, {24'h0, pat(80)[15:8]});
        hwrite(A_CTRL, 1'b0, 32'h1);
        get_word(1, pat(80), "R11 restarted word");
        peek(A_TXS, r); check("R11 sent once", r, EMPTY_ST);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule